// File: doc/BRIEF.md
# Queue Status Interrupt Aggregator

This block gathers the status flags of a bank of hardware queues and reduces them to two interrupt lines. The queue space is split into a lower half and an upper half. Each lower-half queue has its own 3-bit source field that names one of its four status flags and can invert it. Every upper-half queue raises on the same fixed condition, that it is no longer nearly empty.

A rising edge of a queue's condition marks the queue pending, but only while the queue's enable bit is set. Software clears pending bits by writing ones to them. Each half drives its interrupt output while any of its pending bits has its enable bit set. A single register port with a combinational read path holds the source fields, the two enable words and the two pending words. The same port can also read back the upper-half nearly-empty and full vectors.

Top module: `iqa_irq_agg`

## Requirements
- R1: After reset, the source words (addresses 0 to 3), both enable words (4 lower, 5 upper) and both pending words (6 lower, 7 upper) read zero, and both interrupt outputs are low.
- R2: Lower queue q takes its four flags from lo_flags[4q+3:4q], with bit 0 empty, bit 1 nearly empty, bit 2 nearly full and bit 3 full. Bits 1:0 of its source field pick the flag that is tested.
- R3: Bit 2 of a lower queue's source field inverts the picked flag before edge detection.
- R4: The condition of upper queue q is the inverse of hi_nempty[q]. No register alters it.
- R5: A pending bit is set only in a cycle where its queue's condition rises and its enable bit is already set. A condition that stays high does not set the bit again after a clear.
- R6: Writing address 6 or 7 clears the pending bits written as one and leaves the others unchanged.
- R7: When a clear and a set event hit the same pending bit in one cycle, the bit ends up set.
- R8: irq_lo (irq_hi) is high exactly while the lower (upper) pending word AND its enable word is nonzero. Clearing an enable bit drops the line but keeps the pending bit.
- R9: Lower queue q has its source field in word q/8 at bits 4(q%8)+2 to 4(q%8). Bit 4(q%8)+3 is reserved, always reads zero, and writes to it are ignored.
- R10: Address 8 reads hi_nempty and address 9 reads hi_full. Other unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register word address (read and write) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| lo_flags | input | 128 | Four status flags per lower queue |
| hi_nempty | input | 32 | Upper-half nearly-empty flags |
| hi_full | input | 32 | Upper-half full flags |
| irq_lo | output | 1 | Lower-half interrupt |
| irq_hi | output | 1 | Upper-half interrupt |

## Verification
The bench drives a clear and a fresh upper-half edge into the same pending bit in one cycle. A design that let the clear win would lose that interrupt. It holds a lower condition high after clearing its pending bit. A level-sensitive design would set the bit again at once and leave the line stuck. It toggles a condition on a disabled queue and later drops an enable with a bit still pending. These steps catch a design that captures without the enable, and one that discards pending state when masking. Writing all ones to a source word shows whether the reserved bits are stored, and an inverted empty-flag source shows whether the inversion happens before the edge detector.

// File: rtl/iqa_pkg.sv
package iqa_pkg;
    localparam int DATA_W   = 32;
    localparam int NQ_HALF  = DATA_W;
    localparam int SEL_W    = 2;
    localparam int NFLAG    = 1 << SEL_W;
    localparam int SRC_W    = SEL_W + 1;
    localparam int FLD_W    = 4;
    localparam int QPR      = DATA_W / FLD_W;
    localparam int SRC_REGS = NQ_HALF / QPR;
    localparam int A_EN_LO  = SRC_REGS;
    localparam int A_EN_HI  = SRC_REGS + 1;
    localparam int A_PD_LO  = SRC_REGS + 2;
    localparam int A_PD_HI  = SRC_REGS + 3;
    localparam int A_ST_NE  = SRC_REGS + 4;
    localparam int A_ST_FL  = SRC_REGS + 5;

    typedef struct packed {
        logic [SRC_REGS-1:0][DATA_W-1:0] src;
        logic [DATA_W-1:0]               en_lo;
        logic [DATA_W-1:0]               en_hi;
    } regs_t;

    function automatic logic [DATA_W-1:0] src_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int k = 0; k < QPR; k++) begin
            m[k*FLD_W +: SRC_W] = '1;
        end
        return m;
    endfunction
endpackage

// File: rtl/iqa_src_sel.sv
module iqa_src_sel
    import iqa_pkg::*;
#(
    parameter int NQ = NQ_HALF
) (
    input  logic [NQ*NFLAG-1:0] flags,
    input  logic [NQ*SRC_W-1:0] src,
    output logic [NQ-1:0]       cond
);
    for (genvar q = 0; q < NQ; q++) begin : g_q
        logic [SEL_W-1:0] sel;
        logic             inv;
        logic [NFLAG-1:0] fl;
        assign sel = src[q*SRC_W +: SEL_W];
        assign inv = src[q*SRC_W + SEL_W];
        assign fl  = flags[q*NFLAG +: NFLAG];
        assign cond[q] = fl[sel] ^ inv;
    end
endmodule

// File: rtl/iqa_half_capture.sv
module iqa_half_capture #(
    parameter int W    = 32,
    parameter bit EDGE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cond,
    input  logic [W-1:0] en,
    input  logic [W-1:0] clr,
    output logic [W-1:0] set,
    output logic [W-1:0] pend
);
    typedef struct packed {
        logic [W-1:0] cond;
        logic [W-1:0] pend;
    } cap_t;

    cap_t s_d, s_q;

    if (EDGE) begin : g_edge
        assign set = cond & ~s_q.cond & en;
    end else begin : g_level
        assign set = cond & en;
    end

    always_comb begin
        s_d      = s_q;
        s_d.cond = cond;
        s_d.pend = (s_q.pend & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend = s_q.pend;
endmodule

// File: rtl/iqa_irq_agg.sv
module iqa_irq_agg
    import iqa_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter bit EDGE   = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic [NQ_HALF*NFLAG-1:0] lo_flags,
    input  logic [NQ_HALF-1:0]       hi_nempty,
    input  logic [NQ_HALF-1:0]       hi_full,
    output logic                     irq_lo,
    output logic                     irq_hi
);
    localparam logic [DATA_W-1:0] SRC_MASK = src_mask();

    regs_t                     r_d, r_q;
    logic [NQ_HALF-1:0]        clr_lo, clr_hi;
    logic [NQ_HALF-1:0]        cond_lo, cond_hi;
    logic [NQ_HALF-1:0]        set_lo, set_hi;
    logic [NQ_HALF-1:0]        pend_lo, pend_hi;
    logic [NQ_HALF*SRC_W-1:0]  src_flat;
    int                        a;

    assign a = int'(reg_addr);

    for (genvar q = 0; q < NQ_HALF; q++) begin : g_unpack
        assign src_flat[q*SRC_W +: SRC_W] = r_q.src[q / QPR][(q % QPR)*FLD_W +: SRC_W];
    end

    always_comb begin
        r_d    = r_q;
        clr_lo = '0;
        clr_hi = '0;
        if (reg_wr) begin
            for (int i = 0; i < SRC_REGS; i++) begin
                if (a == i) r_d.src[i] = reg_wdata & SRC_MASK;
            end
            if (a == A_EN_LO) r_d.en_lo = reg_wdata;
            if (a == A_EN_HI) r_d.en_hi = reg_wdata;
            if (a == A_PD_LO) clr_lo    = reg_wdata;
            if (a == A_PD_HI) clr_hi    = reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    iqa_src_sel #(.NQ(NQ_HALF)) u_sel (
        .flags (lo_flags),
        .src   (src_flat),
        .cond  (cond_lo)
    );

    assign cond_hi = ~hi_nempty;

    iqa_half_capture #(.W(NQ_HALF), .EDGE(EDGE)) u_cap_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (cond_lo),
        .en    (r_q.en_lo),
        .clr   (clr_lo),
        .set   (set_lo),
        .pend  (pend_lo)
    );

    iqa_half_capture #(.W(NQ_HALF), .EDGE(EDGE)) u_cap_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (cond_hi),
        .en    (r_q.en_hi),
        .clr   (clr_hi),
        .set   (set_hi),
        .pend  (pend_hi)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < SRC_REGS; i++) begin
            if (a == i) reg_rdata = r_q.src[i];
        end
        if (a == A_EN_LO) reg_rdata = r_q.en_lo;
        if (a == A_EN_HI) reg_rdata = r_q.en_hi;
        if (a == A_PD_LO) reg_rdata = pend_lo;
        if (a == A_PD_HI) reg_rdata = pend_hi;
        if (a == A_ST_NE) reg_rdata = hi_nempty;
        if (a == A_ST_FL) reg_rdata = hi_full;
    end

    assign irq_lo = |(pend_lo & r_q.en_lo);
    assign irq_hi = |(pend_hi & r_q.en_hi);
endmodule

// File: rtl/iqa_irq_agg_chk.sv
module iqa_irq_agg_chk
    import iqa_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               irq_lo,
    input logic               irq_hi,
    input logic [NQ_HALF-1:0] en_lo,
    input logic [NQ_HALF-1:0] en_hi,
    input logic [NQ_HALF-1:0] pend_lo,
    input logic [NQ_HALF-1:0] pend_hi,
    input logic [NQ_HALF-1:0] cond_lo,
    input logic [NQ_HALF-1:0] cond_hi,
    input logic [NQ_HALF-1:0] set_lo,
    input logic [NQ_HALF-1:0] clr_lo
);
    // R5: a newly pending bit had its enable set in the previous cycle
    p_set_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_lo & ~$past(pend_lo) & ~$past(en_lo)) == '0));

    // R5: a newly pending bit had its condition high in the previous cycle
    p_set_needs_cond_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_hi & ~$past(pend_hi) & ~$past(cond_hi)) == '0));

    // R6: a cleared bit without a concurrent set is gone next cycle
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_lo & $past(clr_lo) & ~$past(set_lo)) == '0));

    // R8: no line without an enable
    p_irq_lo_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_lo == '0) |-> !irq_lo);

    p_irq_hi_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_hi == '0) |-> !irq_hi);

    // R2: a lower condition that stayed low cannot have set a bit
    p_lo_cond_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_lo & ~$past(pend_lo) & ~$past(cond_lo)) == '0));
endmodule

bind iqa_irq_agg iqa_irq_agg_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_lo  (irq_lo),
    .irq_hi  (irq_hi),
    .en_lo   (r_q.en_lo),
    .en_hi   (r_q.en_hi),
    .pend_lo (pend_lo),
    .pend_hi (pend_hi),
    .cond_lo (cond_lo),
    .cond_hi (cond_hi),
    .set_lo  (set_lo),
    .clr_lo  (clr_lo)
);

// File: tb/sim_iqa_irq_agg.sv
module sim_iqa_irq_agg;
    localparam int CLK_P = 10;
    localparam int NQ    = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [127:0] lo_flags;
    logic [31:0]  hi_nempty = '1;
    logic [31:0]  hi_full = '0;
    logic         irq_lo, irq_hi;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    logic [31:0] m_src [4];
    logic [31:0] m_en_lo, m_en_hi, m_pd_lo, m_pd_hi, m_cq_lo, m_cq_hi;

    always #(CLK_P/2) clk = ~clk;

    iqa_irq_agg u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lo_flags(lo_flags),
        .hi_nempty(hi_nempty), .hi_full(hi_full), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    function automatic logic [31:0] m_read(input int ad);
        if (ad < 4)  return m_src[ad];
        if (ad == 4) return m_en_lo;
        if (ad == 5) return m_en_hi;
        if (ad == 6) return m_pd_lo;
        if (ad == 7) return m_pd_hi;
        if (ad == 8) return hi_nempty;
        if (ad == 9) return hi_full;
        return 32'h0;
    endfunction

    // behavioural reference, updated at every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_src[i] = '0;
            m_en_lo = '0; m_en_hi = '0; m_pd_lo = '0; m_pd_hi = '0;
            m_cq_lo = '0; m_cq_hi = '0;
        end else begin
            logic [31:0] cl, ch, sl, sh, kl, kh;
            for (int q = 0; q < NQ; q++) begin
                int f, sel;
                f   = (m_src[q/8] >> (4*(q%8))) & 7;
                sel = f & 3;
                cl[q] = lo_flags[4*q + sel] ^ ((f & 4) != 0);
            end
            ch = ~hi_nempty;
            sl = cl & ~m_cq_lo & m_en_lo;
            sh = ch & ~m_cq_hi & m_en_hi;
            kl = (reg_wr && reg_addr == 6) ? reg_wdata : '0;
            kh = (reg_wr && reg_addr == 7) ? reg_wdata : '0;
            m_pd_lo = (m_pd_lo & ~kl) | sl;
            m_pd_hi = (m_pd_hi & ~kh) | sh;
            m_cq_lo = cl;
            m_cq_hi = ch;
            if (reg_wr && reg_addr < 4) m_src[reg_addr] = reg_wdata & 32'h7777_7777;
            if (reg_wr && reg_addr == 4) m_en_lo = reg_wdata;
            if (reg_wr && reg_addr == 5) m_en_hi = reg_wdata;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // compare against the reference a quarter period after each edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (rst_n && !done) begin
            logic [31:0] ex;
            string tg;
            ex = m_read(int'(reg_addr));
            tg = (reg_addr < 4) ? "R9" : (reg_addr < 6) ? "R8" : (reg_addr < 8) ? "R5" : "R10";
            check("R8 irq_lo", {31'b0, irq_lo}, {31'b0, |(m_pd_lo & m_en_lo)});
            check("R8 irq_hi", {31'b0, irq_hi}, {31'b0, |(m_pd_hi & m_en_hi)});
            check(tg, reg_rdata, ex);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
            finish_run();
        end
    end

    task automatic wr(input int ad, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(ad); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int ad, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = 4'(ad);
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        lo_flags = '0;
        for (int q = 0; q < NQ; q++) lo_flags[4*q] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int ad = 0; ad < 8; ad++) rd(ad, 32'h0, "R1");
        check("R1 irq_lo", {31'b0, irq_lo}, 32'h0);
        check("R1 irq_hi", {31'b0, irq_hi}, 32'h0);

        // R9: reserved bits dropped
        wr(0, 32'hFFFF_FFFF);
        rd(0, 32'h7777_7777, "R9");
        wr(0, 32'h0);

        // R2: queue 3 tests nearly-full flag
        wr(0, 32'h2 << 12);
        wr(4, 32'h1 << 3);
        @(negedge clk); lo_flags[4*3+2] = 1'b1;
        settle();
        rd(6, 32'h0000_0008, "R2");
        check("R2 irq_lo", {31'b0, irq_lo}, 32'h1);

        // R3: queue 5 tests inverted empty flag
        wr(0, (32'h2 << 12) | (32'h4 << 20));
        wr(4, (32'h1 << 3) | (32'h1 << 5));
        rd(6, 32'h0000_0008, "R3 no set before edge");
        @(negedge clk); lo_flags[4*5] = 1'b0;
        settle();
        rd(6, 32'h0000_0028, "R3");

        // R6: clear one bit, the other stays
        wr(6, 32'h1 << 3);
        rd(6, 32'h0000_0020, "R6");
        // R5: held condition does not re-set
        settle(); settle();
        rd(6, 32'h0000_0020, "R5 level held");

        // R5: edge on a disabled queue is ignored
        @(negedge clk); lo_flags[4*7] = 1'b0;
        settle();
        @(negedge clk); lo_flags[4*7] = 1'b1;
        settle();
        rd(6, 32'h0000_0020, "R5 disabled");

        // R4: upper queue 2 raises on not nearly empty
        wr(5, 32'h1 << 2);
        @(negedge clk); hi_nempty[2] = 1'b0;
        settle();
        rd(7, 32'h0000_0004, "R4");
        check("R4 irq_hi", {31'b0, irq_hi}, 32'h1);

        // R7: clear and set of bit 4 in the same cycle
        wr(5, (32'h1 << 2) | (32'h1 << 4));
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd7; reg_wdata = (32'h1 << 2) | (32'h1 << 4);
        hi_nempty[4] = 1'b0;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(7, 32'h0000_0010, "R7");

        // R8: masking drops the line, keeps pending
        wr(5, 32'h0);
        check("R8 irq_hi masked", {31'b0, irq_hi}, 32'h0);
        rd(7, 32'h0000_0010, "R8 pend kept");
        check("R8 irq_lo still", {31'b0, irq_lo}, 32'h1);
        wr(4, 32'h0);
        check("R8 irq_lo masked", {31'b0, irq_lo}, 32'h0);

        // R10: status vectors and unused address
        @(negedge clk); hi_full = 32'hA5A5_0F0F;
        rd(9, 32'hA5A5_0F0F, "R10 full");
        rd(8, 32'hFFFF_FFEB, "R10 nempty");
        rd(12, 32'h0, "R10 unused");

        settle();
        finish_run();
    end
endmodule